// File: doc/BRIEF.md
# Directory Home Slice for Block Coherence

This block is the home agent for a group of cache blocks in a small multiprocessor. For every block it keeps one entry holding a dirty flag and one presence flag per cache. Read and write requests arrive from the network one at a time, and the slice services each to completion before it accepts another. That single point of acceptance fixes the order in which all requests to a block take effect. While servicing a request the slice sends point-to-point invalidate or downgrade messages to the caches that hold the block. It waits for each acknowledgement, moves returned dirty data into memory, reads memory when it has no fresher copy, and ends with a grant to the requester marked exclusive or shared.

A set dirty flag means exactly one cache holds the block with the right to write it, whether it is clean or modified there. Requests and acknowledgements name caches by index, 0 to 7, and blocks by a 4-bit index, 0 to 15. The memory port is a one-cycle read strobe answered by `mem_rvalid` some cycles later, plus a one-cycle write strobe.

The controller has eight states:

- IDLE: the only state in which a request is taken.
- DISPATCH: the entry is examined.
- SNOOP: one invalidate or downgrade message is sent.
- ACK_WAIT: the slice waits for the addressed cache to answer.
- WRBACK: returned data is written to memory.
- MEM_RD: a memory read is issued.
- MEM_WAIT: the slice waits for the memory data.
- GRANT: the grant is sent.

Its transitions are as follows:

- IDLE to DISPATCH on an accepted request.
- DISPATCH to SNOOP when other holders exist and either the request is a write or the block is dirty. DISPATCH to MEM_RD otherwise.
- SNOOP to ACK_WAIT.
- ACK_WAIT to WRBACK on a matching acknowledgement that carries data.
- ACK_WAIT back to SNOOP on a matching acknowledgement without data, during a write that still has holders to remove.
- ACK_WAIT to GRANT on a matching acknowledgement without data, when data is already held.
- ACK_WAIT to MEM_RD on any other matching acknowledgement without data.
- WRBACK to SNOOP while write invalidations remain, and to GRANT otherwise.
- MEM_RD to MEM_WAIT.
- MEM_WAIT to GRANT on `mem_rvalid`.
- GRANT to IDLE.

Top module: `dir_slice`

## Requirements
- R1: After reset `req_ready` is 1, no message output is active, and every entry is empty, so the first read of any block is granted exclusive.
- R2: A read from cache s, where no cache other than s is present, issues one memory read and then grants s exclusive (`gnt_excl`=1) with the memory data. The entry becomes only s present, with the dirty flag set.
- R3: A read from cache s to a block with other holders and a clear dirty flag issues one memory read and no snoop. It grants s shared (`gnt_excl`=0), adds s to the holders and leaves the dirty flag clear.
- R4: A read to a block that is dirty in another cache h sends one downgrade (`snp_downgrade`=1, `snp_dst`=h). If h acknowledges with data D, the slice writes D to memory, skips the memory read and grants the reader shared with D. Both h and the reader stay present and the dirty flag clears.
- R5: In the R4 case, an acknowledgement without data makes the slice read memory and grant the reader shared with the memory data. The dirty flag clears and both caches stay present.
- R6: A write from cache w to a block with holders other than w sends one invalidate (`snp_downgrade`=0) per holder, lowest cache index first. Each message waits for the previous acknowledgement, and each acknowledgement removes that cache's presence flag.
- R7: An invalidation acknowledgement carrying data D causes a memory write of D, and the writer is granted exclusive with D without any memory read.
- R8: When a write has removed all other holders and no data came back, or when the write found none, the slice reads memory and grants the writer exclusive. The writer is then the only holder, with the dirty flag set.
- R9: An acknowledgement whose `ack_src` differs from the cache last snooped is ignored: it writes no memory, changes no entry and does not advance the request.
- R10: A request is accepted only while `req_ready` is 1, which is only in IDLE. `req_ready` stays 0 from acceptance through the grant, and requests presented meanwhile have no effect.
- R11: Each of `snp_valid`, `mem_rd_req`, `mem_wr_req` and `gnt_valid` is a one-cycle pulse, at most one is active in any cycle, and `req_ready` returns to 1 the cycle after a grant.
- R12: Entries of different block indices are independent, and `mem_blk` always carries the index of the request being served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice idle; request accepted this cycle if valid |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_src | input | 3 | Requesting cache index |
| req_blk | input | 4 | Block index |
| snp_valid | output | 1 | Snoop message pulse |
| snp_dst | output | 3 | Cache addressed by the snoop |
| snp_downgrade | output | 1 | 1 = downgrade to shared, 0 = invalidate |
| ack_valid | input | 1 | Snoop acknowledgement present |
| ack_src | input | 3 | Cache sending the acknowledgement |
| ack_has_data | input | 1 | Acknowledgement carries the block data |
| ack_data | input | 32 | Returned block data |
| mem_rd_req | output | 1 | Memory read strobe |
| mem_wr_req | output | 1 | Memory write strobe |
| mem_blk | output | 4 | Block index for memory access |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| gnt_valid | output | 1 | Grant pulse to the requester |
| gnt_dst | output | 3 | Cache receiving the grant |
| gnt_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| gnt_data | output | 32 | Block data sent with the grant |

## Verification
The requests are chosen so that each arm of DISPATCH is taken at least once: an empty block, a clean shared block, a block dirty in another cache, and a write that finds several sharers including the writer itself. Downgrade and invalidate acknowledgements are tried both with and without data. This separates the memory-write path from the re-read path, and the message sequence shows which of the two was taken. One write receives a stray acknowledgement with data from the wrong cache while unrelated requests are held on the input, so any premature progress or acceptance appears as an extra message. Traffic on a second block, interleaved with the first, shows whether the entries are independent.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DISPATCH,
        S_SNOOP,
        S_ACK_WAIT,
        S_WRBACK,
        S_MEM_RD,
        S_MEM_WAIT,
        S_GRANT
    } dir_state_e;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
    parameter int N_CACHES = 8,
    parameter int N_BLOCKS = 16,
    localparam int IW = $clog2(N_BLOCKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IW-1:0]       rd_idx,
    output logic [N_CACHES-1:0] rd_pres,
    output logic                rd_dirty,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [N_CACHES-1:0] wr_pres,
    input  logic                wr_dirty
);

    logic [N_CACHES-1:0] pres_q  [N_BLOCKS];
    logic                dirty_q [N_BLOCKS];

    for (genvar b = 0; b < N_BLOCKS; b++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pres_q[b]  <= '0;
                dirty_q[b] <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(b))) begin
                pres_q[b]  <= wr_pres;
                dirty_q[b] <= wr_dirty;
            end
        end
    end

    assign rd_pres  = pres_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

endmodule

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = i[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/dir_slice.sv
module dir_slice #(
    parameter int N_CACHES = 8,
    parameter int N_BLOCKS = 16,
    parameter int DATA_W   = 32,
    localparam int SW = $clog2(N_CACHES),
    localparam int IW = $clog2(N_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [SW-1:0]     req_src,
    input  logic [IW-1:0]     req_blk,
    output logic              snp_valid,
    output logic [SW-1:0]     snp_dst,
    output logic              snp_downgrade,
    input  logic              ack_valid,
    input  logic [SW-1:0]     ack_src,
    input  logic              ack_has_data,
    input  logic [DATA_W-1:0] ack_data,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [IW-1:0]     mem_blk,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              gnt_valid,
    output logic [SW-1:0]     gnt_dst,
    output logic              gnt_excl,
    output logic [DATA_W-1:0] gnt_data
);
    import dir_pkg::*;

    dir_state_e state_q, state_d;

    logic              wr_q, excl_q, have_q;
    logic [SW-1:0]     src_q, tgt_q;
    logic [IW-1:0]     blk_q;
    logic [DATA_W-1:0] data_q;

    logic [N_CACHES-1:0] ent_pres, new_pres, src_oh, tgt_oh, others, after_ack;
    logic                ent_dirty, new_dirty, ent_we;
    logic                pk_any, ack_hit;
    logic [SW-1:0]       pk_idx;

    dir_entry_store #(.N_CACHES(N_CACHES), .N_BLOCKS(N_BLOCKS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (blk_q),
        .rd_pres  (ent_pres),
        .rd_dirty (ent_dirty),
        .wr_en    (ent_we),
        .wr_idx   (blk_q),
        .wr_pres  (new_pres),
        .wr_dirty (new_dirty)
    );

    assign src_oh    = {{(N_CACHES-1){1'b0}}, 1'b1} << src_q;
    assign tgt_oh    = {{(N_CACHES-1){1'b0}}, 1'b1} << tgt_q;
    assign others    = ent_pres & ~src_oh;
    assign after_ack = others & ~tgt_oh;
    assign ack_hit   = (state_q == S_ACK_WAIT) && ack_valid && (ack_src == tgt_q);

    dir_lowest_pick #(.N(N_CACHES)) u_pick (
        .vec (others),
        .any (pk_any),
        .idx (pk_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_DISPATCH;
            S_DISPATCH: state_d = (pk_any && (wr_q || ent_dirty)) ? S_SNOOP : S_MEM_RD;
            S_SNOOP:    state_d = S_ACK_WAIT;
            S_ACK_WAIT: begin
                if (ack_hit) begin
                    if (ack_has_data)            state_d = S_WRBACK;
                    else if (wr_q && |after_ack) state_d = S_SNOOP;
                    else if (have_q)             state_d = S_GRANT;
                    else                         state_d = S_MEM_RD;
                end
            end
            S_WRBACK:   state_d = (wr_q && pk_any) ? S_SNOOP : S_GRANT;
            S_MEM_RD:   state_d = S_MEM_WAIT;
            S_MEM_WAIT: if (mem_rvalid) state_d = S_GRANT;
            S_GRANT:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            excl_q <= 1'b0;
            have_q <= 1'b0;
            src_q  <= '0;
            tgt_q  <= '0;
            blk_q  <= '0;
            data_q <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                wr_q   <= req_write;
                src_q  <= req_src;
                blk_q  <= req_blk;
                have_q <= 1'b0;
            end
            if (state_q == S_DISPATCH) excl_q <= wr_q | ~pk_any;
            if (state_q == S_SNOOP)    tgt_q  <= pk_idx;
            if (ack_hit && ack_has_data) begin
                data_q <= ack_data;
                have_q <= 1'b1;
            end
            if (state_q == S_MEM_WAIT && mem_rvalid) data_q <= mem_rdata;
        end
    end

    // entry update
    always_comb begin
        ent_we    = 1'b0;
        new_pres  = ent_pres;
        new_dirty = ent_dirty;
        if (ack_hit) begin
            ent_we    = 1'b1;
            new_pres  = wr_q ? (ent_pres & ~tgt_oh) : ent_pres;
            new_dirty = ack_has_data ? ent_dirty : 1'b0;
        end else if (state_q == S_GRANT) begin
            ent_we    = 1'b1;
            new_pres  = excl_q ? src_oh : (ent_pres | src_oh);
            new_dirty = excl_q;
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        snp_valid     = (state_q == S_SNOOP);
        snp_dst       = pk_idx;
        snp_downgrade = ~wr_q;
        mem_rd_req    = (state_q == S_MEM_RD);
        mem_wr_req    = (state_q == S_WRBACK);
        mem_blk       = blk_q;
        mem_wdata     = data_q;
        gnt_valid     = (state_q == S_GRANT);
        gnt_dst       = src_q;
        gnt_excl      = excl_q;
        gnt_data      = data_q;
    end

endmodule

// File: rtl/dir_slice_chk.sv
module dir_slice_chk #(
    parameter int N_CACHES = 8,
    localparam int SW = $clog2(N_CACHES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                snp_valid,
    input logic [SW-1:0]       snp_dst,
    input logic                mem_rd_req,
    input logic                mem_wr_req,
    input logic                gnt_valid,
    input logic                gnt_excl,
    input logic                ack_valid,
    input logic [SW-1:0]       ack_src,
    input logic                wr_q,
    input logic [SW-1:0]       tgt_q,
    input logic [N_CACHES-1:0] ent_pres,
    input dir_pkg::dir_state_e state_q
);
    import dir_pkg::*;

    p_one_msg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snp_valid, mem_rd_req, mem_wr_req, gnt_valid}));

    p_ready_after_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> req_ready);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_snoop_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> !snp_valid);

    p_snoop_holder_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> ent_pres[snp_dst]);

    p_write_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && wr_q) |-> gnt_excl);

    p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK_WAIT && ack_valid && ack_src != tgt_q)
        |=> !(mem_wr_req || mem_rd_req || gnt_valid || snp_valid));

endmodule

bind dir_slice dir_slice_chk #(.N_CACHES(N_CACHES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .snp_valid  (snp_valid),
    .snp_dst    (snp_dst),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .gnt_valid  (gnt_valid),
    .gnt_excl   (gnt_excl),
    .ack_valid  (ack_valid),
    .ack_src    (ack_src),
    .wr_q       (wr_q),
    .tgt_q      (tgt_q),
    .ent_pres   (ent_pres),
    .state_q    (state_q)
);

// File: tb/test_dir_slice.sv
module test_dir_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_src = '0;
    logic [3:0]  req_blk = '0;
    logic        req_ready;
    logic        snp_valid, snp_downgrade;
    logic [2:0]  snp_dst;
    logic        ack_valid = 1'b0, ack_has_data = 1'b0;
    logic [2:0]  ack_src = '0;
    logic [31:0] ack_data = '0;
    logic        mem_rd_req, mem_wr_req;
    logic [3:0]  mem_blk;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        gnt_valid, gnt_excl;
    logic [2:0]  gnt_dst;
    logic [31:0] gnt_data;

    always #5 clk = ~clk;

    dir_slice i_dir_slice (.*);

    // reference state
    int          checks = 0, failures = 0;
    logic [7:0]  pres [16];
    bit          dty [16];
    logic [31:0] bmem [16];
    logic [7:0]  wbmask = '0;
    logic [31:0] cval [8];
    logic [39:0] eq [$];
    string       tq [$];
    int          ack_cnt = 0, rd_cnt = 0;
    logic [2:0]  ack_to = '0;
    bit          busy = 0, noise = 0, stray = 0, stray_done = 0;
    int          cur_blk = 0;
    bit          done = 0;

    localparam logic [2:0] E_SNP = 3'd1, E_RD = 3'd2, E_WR = 3'd3, E_GNT = 3'd4;

    function automatic logic [39:0] ev(logic [2:0] t, logic [2:0] d, logic f, logic [31:0] v);
        return {t, 1'b0, d, f, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic expect_ev(input logic [39:0] e, input string tag);
        eq.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic cmp(input logic [39:0] got);
        logic [39:0] exp;
        string t;
        if (eq.size() == 0) begin
            chk(1'b0, "R11 unexpected message", 64'(got), 64'(0));
        end else begin
            exp = eq.pop_front();
            t   = tq.pop_front();
            chk(got === exp, t, 64'(got), 64'(exp));
        end
    endtask

    // one clock: sample at negedge, update models, drive next inputs
    task automatic step();
        @(negedge clk);
        if (snp_valid) begin
            cmp(ev(E_SNP, snp_dst, snp_downgrade, 32'h0));
            ack_cnt = 1;
            ack_to  = snp_dst;
        end
        if (mem_rd_req) begin
            cmp(ev(E_RD, 3'd0, 1'b0, 32'h0));
            chk(mem_blk == 4'(cur_blk), "R12 read index", 64'(mem_blk), 64'(cur_blk));
            rd_cnt = 2;
        end
        if (mem_wr_req) begin
            cmp(ev(E_WR, 3'd0, 1'b0, mem_wdata));
            chk(mem_blk == 4'(cur_blk), "R12 write index", 64'(mem_blk), 64'(cur_blk));
            bmem[mem_blk] = mem_wdata;
        end
        if (gnt_valid) begin
            cmp(ev(E_GNT, gnt_dst, gnt_excl, gnt_data));
            busy = 0;
        end
        if (busy && req_ready)
            chk(1'b0, "R10 ready while busy", 64'(1), 64'(0));
        // drive
        ack_valid  = 1'b0;
        mem_rvalid = 1'b0;
        if (ack_cnt == 2) begin
            if (stray && !stray_done) begin
                ack_valid = 1'b1; ack_src = ack_to + 3'd1;
                ack_has_data = 1'b1; ack_data = 32'hDEAD_BEEF;
                stray_done = 1;
            end else begin
                ack_valid = 1'b1; ack_src = ack_to;
                ack_has_data = wbmask[ack_to]; ack_data = cval[ack_to];
                ack_cnt = 0;
            end
        end else if (ack_cnt == 1) begin
            ack_cnt = 2;
        end
        if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = bmem[cur_blk];
            end
        end
        if (busy && noise) begin
            req_valid = 1'b1; req_write = 1'b0; req_src = 3'd7; req_blk = 4'd15;
        end else begin
            req_valid = 1'b0;
        end
    endtask

    task automatic do_req(input bit wr, input int src, input int a, input bit noisy,
                          input bit stray_on, input string tag);
        logic [7:0]  others;
        logic [31:0] d;
        bit          hd;
        int          n;
        others = pres[a] & ~(8'd1 << src);
        if (wr) begin
            hd = 0;
            d  = bmem[a];
            for (int c = 0; c < 8; c++) begin
                if (others[c]) begin
                    expect_ev(ev(E_SNP, 3'(c), 1'b0, 32'h0), tag);
                    if (wbmask[c]) begin
                        expect_ev(ev(E_WR, 3'd0, 1'b0, cval[c]), tag);
                        hd = 1; d = cval[c];
                    end
                end
            end
            if (!hd) expect_ev(ev(E_RD, 3'd0, 1'b0, 32'h0), tag);
            expect_ev(ev(E_GNT, 3'(src), 1'b1, d), tag);
            pres[a] = 8'd1 << src; dty[a] = 1;
        end else if (others == 0) begin
            expect_ev(ev(E_RD, 3'd0, 1'b0, 32'h0), tag);
            expect_ev(ev(E_GNT, 3'(src), 1'b1, bmem[a]), tag);
            pres[a] = 8'd1 << src; dty[a] = 1;
        end else if (dty[a]) begin
            for (int c = 0; c < 8; c++) begin
                if (others[c]) begin
                    expect_ev(ev(E_SNP, 3'(c), 1'b1, 32'h0), tag);
                    if (wbmask[c]) begin
                        expect_ev(ev(E_WR, 3'd0, 1'b0, cval[c]), tag);
                        expect_ev(ev(E_GNT, 3'(src), 1'b0, cval[c]), tag);
                    end else begin
                        expect_ev(ev(E_RD, 3'd0, 1'b0, 32'h0), tag);
                        expect_ev(ev(E_GNT, 3'(src), 1'b0, bmem[a]), tag);
                    end
                end
            end
            pres[a] = pres[a] | (8'd1 << src); dty[a] = 0;
        end else begin
            expect_ev(ev(E_RD, 3'd0, 1'b0, 32'h0), tag);
            expect_ev(ev(E_GNT, 3'(src), 1'b0, bmem[a]), tag);
            pres[a] = pres[a] | (8'd1 << src);
        end
        chk(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'(1));
        cur_blk = a; stray = stray_on; stray_done = 0; noise = noisy;
        req_valid = 1'b1; req_write = wr; req_src = 3'(src); req_blk = 4'(a);
        busy = 1;
        n = 0;
        while (busy && n < 60) begin
            step();
            n++;
        end
        if (busy) begin
            chk(1'b0, {tag, " no grant"}, 64'(0), 64'(1));
            busy = 0;
        end
        step();
        chk(req_ready == 1'b1 && eq.size() == 0, "R11 idle after grant",
            64'({req_ready, 8'(eq.size())}), 64'({1'b1, 8'd0}));
        eq.delete(); tq.delete();
        noise = 0; stray = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R11 got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 16; i++) begin
            pres[i] = '0; dty[i] = 0; bmem[i] = 32'hA000_0000 + 32'(i);
        end
        for (int c = 0; c < 8; c++) cval[c] = 32'hC000_0000 + 32'(c);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1: idle outputs after reset
        chk(req_ready && !snp_valid && !mem_rd_req && !mem_wr_req && !gnt_valid, "R1 reset outputs",
            64'({req_ready, snp_valid, mem_rd_req, mem_wr_req, gnt_valid}), 64'(5'b10000));

        // R1, R2: first read of block 3 gets exclusive memory data
        do_req(1'b0, 1, 3, 1'b0, 1'b0, "R2");
        // R2: re-read by the sole holder stays exclusive
        do_req(1'b0, 1, 3, 1'b0, 1'b0, "R2");
        // R4: downgrade of holder 1 with data
        wbmask = 8'b0000_0010; cval[1] = 32'h0000_0011;
        do_req(1'b0, 2, 3, 1'b0, 1'b0, "R4");
        // R3: clean shared read
        wbmask = '0;
        do_req(1'b0, 5, 3, 1'b0, 1'b0, "R3");
        // R6, R8, R9, R10: write invalidates 1 then 5, stray ack and held requests ignored
        do_req(1'b1, 2, 3, 1'b1, 1'b1, "R6 R8 R9 R10");
        // R5: downgrade answered without data
        do_req(1'b0, 4, 3, 1'b0, 1'b0, "R5");
        // R12: block 9 is independent; fresh write
        do_req(1'b1, 0, 9, 1'b0, 1'b0, "R8 R12");
        // R7: invalidate returns data
        wbmask = 8'b0000_0001; cval[0] = 32'h0000_0077;
        do_req(1'b1, 7, 9, 1'b0, 1'b1, "R7 R9");
        wbmask = '0;
        // R12: block 3 entry unaffected by block 9 traffic, clean shared read
        do_req(1'b0, 1, 3, 1'b0, 1'b0, "R3 R12");
        // R6: upgrade write from a present cache, lowest holder first
        do_req(1'b1, 4, 3, 1'b1, 1'b0, "R6 R10");
        // R2: read of block 9 by its holder stays exclusive
        do_req(1'b0, 7, 9, 1'b0, 1'b0, "R2 R12");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule